// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This peripheral is a watchdog countdown timer with a 16-bit data register interface. It is paced by a slow tick input that pulses once every 10 ms. Software programs a timeout in ticks and then keeps the count from reaching zero by writing a feed key. If the count runs out while the timer is enabled, the block issues a one-clock reset request and records a sticky timed-out status.

Every state-changing action must carry its own 16-bit key value, so a stray write cannot feed, stop, restart or clear the block. Stopping the timer takes two keyed writes that must arrive back to back on two separate registers. One tick before expiry the block raises an early-warning event, which can be masked onto an interrupt line or forced by software. The live count can be read at any time, and a flag marks a read that was taken while the count was changing. A debug-mode input holds the timer still unless software explicitly allows it to run.

The block sits behind a bus bridge. A write happens on one clock edge when `wr_en` is high. Read data is registered, so `rdata` shows the register addressed one cycle earlier. The value reflects the state before that edge.

Top module: `kwdt_top`

## Requirements
- R1: After reset the timer is disabled, so disable-2 (0x0C) reads 0xDABE. Status (0x10) reads 0x0000, the count equals the default timeout, and both `irq` and `reset_req` are low.
- R2: Writing 0xFEED to offset 0x00 reloads the count from the timeout register. Any other value written there leaves the count unchanged.
- R3: The timeout register at 0x04 holds 15 bits. A write keeps `wdata[14:0]`, and a read returns that value with bit 15 clear.
- R4: Each tick taken while the timer is running lowers the count by one. Ticks have no effect while the timer is disabled.
- R5: A tick taken at count 0 while running pulses `reset_req` high for exactly one clock on the following edge, sets the sticky timed-out status and reloads the count from the timeout register.
- R6: Writing 0x2BAD to 0x08 and then, as the very next write, 0xCAFE to 0x0C disables the timer. Any other write in between aborts the sequence. Disable-2 reads 0xDABE when disabled and 0x0000 when enabled.
- R7: Writing 0xACED to offset 0x1C enables a disabled timer. Any other value has no effect.
- R8: Status reads 0xCFE8 after an expiry. Only a write of 0xE8B4 to 0x10 returns it to 0x0000.
- R9: The count register at 0x14 returns the count in bits [14:0]. Bit 15 reads 1 when the read is sampled on an edge where a running tick is applied, and 0 otherwise.
- R10: A tick taken at count 1 while running sets bit 0 of the event register (0x20), and writing 1 to that bit clears it. `irq` follows event AND mask bit 0 (0x24) one clock later.
- R11: While bit 0 of the force register (0x28) is 1, the event bit is held set and an acknowledge does not clear it.
- R12: Bit 1 of the debug register (0x18) reads the `dbg_mode` input. While `dbg_mode` is high, ticks are ignored unless bit 0 of that register has been written as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock pulse every 10 ms |
| dbg_mode | input | 1 | Debug mode active |
| wr_en | input | 1 | Write strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data for the previous address |
| irq | output | 1 | Early-warning interrupt |
| reset_req | output | 1 | One-clock reset request on expiry |

## Verification
Several checks run on every cycle. A running tick decrements the count by exactly one. `reset_req` is always accompanied by the sticky status, and the status only drops on its clear key. The timer can only become disabled when the first disable key was armed, and the event bit can only rise from a warning tick or a force. The bench scenarios are needed for everything else:

- rejection of wrong key values and of interrupted disable sequences;
- the exact read codes;
- the stability flag;
- the one-cycle interrupt latency;
- the debug hold.

Random feeds with random timeouts and tick counts compare the live count against a model.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned IDX_W = 4;

  localparam logic [IDX_W-1:0] IX_FEED  = 4'h0;
  localparam logic [IDX_W-1:0] IX_TMO   = 4'h1;
  localparam logic [IDX_W-1:0] IX_DIS1  = 4'h2;
  localparam logic [IDX_W-1:0] IX_DIS2  = 4'h3;
  localparam logic [IDX_W-1:0] IX_STAT  = 4'h4;
  localparam logic [IDX_W-1:0] IX_CNT   = 4'h5;
  localparam logic [IDX_W-1:0] IX_DBG   = 4'h6;
  localparam logic [IDX_W-1:0] IX_RSTRT = 4'h7;
  localparam logic [IDX_W-1:0] IX_EVT   = 4'h8;
  localparam logic [IDX_W-1:0] IX_MASK  = 4'h9;
  localparam logic [IDX_W-1:0] IX_FORCE = 4'hA;

  localparam logic [15:0] K_FEED    = 16'hFEED;
  localparam logic [15:0] K_DIS1    = 16'h2BAD;
  localparam logic [15:0] K_DIS2    = 16'hCAFE;
  localparam logic [15:0] K_RESTART = 16'hACED;
  localparam logic [15:0] K_CLEAR   = 16'hE8B4;
  localparam logic [15:0] C_OFF     = 16'hDABE;
  localparam logic [15:0] C_EXPIRED = 16'hCFE8;
endpackage

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
#(
  parameter int unsigned CNT_W = 15,
  parameter int unsigned DEF_TIMEOUT = 6000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [15:0]      wdata,
  output logic             feed_hit,
  output logic             clr_hit,
  output logic             ack_hit,
  output logic             enabled,
  output logic             dbg_run,
  output logic             mask_q,
  output logic             force_q,
  output logic [CNT_W-1:0] timeout_q
);
  logic armed_q;
  logic dis1_hit, dis2_hit, restart_hit;

  always_comb begin
    feed_hit    = wr_en && idx == IX_FEED  && wdata == K_FEED;
    clr_hit     = wr_en && idx == IX_STAT  && wdata == K_CLEAR;
    ack_hit     = wr_en && idx == IX_EVT   && wdata[0];
    dis1_hit    = wr_en && idx == IX_DIS1  && wdata == K_DIS1;
    dis2_hit    = wr_en && idx == IX_DIS2  && wdata == K_DIS2 && armed_q;
    restart_hit = wr_en && idx == IX_RSTRT && wdata == K_RESTART;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      enabled   <= 1'b0;
      dbg_run   <= 1'b0;
      mask_q    <= 1'b0;
      force_q   <= 1'b0;
      timeout_q <= CNT_W'(DEF_TIMEOUT);
    end else if (wr_en) begin
      armed_q <= dis1_hit;
      if (dis2_hit) enabled <= 1'b0;
      else if (restart_hit) enabled <= 1'b1;
      if (idx == IX_TMO)   timeout_q <= wdata[CNT_W-1:0];
      if (idx == IX_DBG)   dbg_run   <= wdata[0];
      if (idx == IX_MASK)  mask_q    <= wdata[0];
      if (idx == IX_FORCE) force_q   <= wdata[0];
    end
  end

  // R6
  disarm_only_by_key_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(enabled) |-> $past(armed_q));
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int unsigned CNT_W = 15,
  parameter int unsigned DEF_TIMEOUT = 6000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             running,
  input  logic             feed,
  input  logic             clr,
  input  logic [CNT_W-1:0] timeout,
  output logic [CNT_W-1:0] count,
  output logic             expired_q,
  output logic             warn,
  output logic             reset_req
);
  logic step, at_zero;

  always_comb begin
    step    = tick && running && !feed;
    at_zero = count == '0;
    warn    = step && count == CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= CNT_W'(DEF_TIMEOUT);
      expired_q <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      reset_req <= step && at_zero;
      if (feed) count <= timeout;
      else if (step) count <= at_zero ? timeout : count - 1'b1;
      if (step && at_zero) expired_q <= 1'b1;
      else if (clr) expired_q <= 1'b0;
    end
  end

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !at_zero) |=> count == $past(count) - 1'b1);
  // R5
  req_has_status_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> expired_q);
  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (expired_q && !clr) |=> expired_q);
endmodule

// File: rtl/kwdt_irq.sv
module kwdt_irq (
  input  logic clk,
  input  logic rst,
  input  logic warn,
  input  logic force_q,
  input  logic ack,
  input  logic mask_q,
  output logic evt_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (warn || force_q) evt_q <= 1'b1;
      else if (ack) evt_q <= 1'b0;
      irq <= evt_q && mask_q;
    end
  end

  // R10
  evt_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_q) |-> $past(warn || force_q));
  // R11
  force_holds_chk: assert property (@(posedge clk) disable iff (rst)
    force_q |=> evt_q);
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W = 15,
  parameter int unsigned DEF_TIMEOUT = 6000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              dbg_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              irq,
  output logic              reset_req
);
  logic [IDX_W-1:0] idx;
  logic feed_hit, clr_hit, ack_hit, enabled, dbg_run, mask_q, force_q;
  logic expired_q, warn, evt_q, running;
  logic [CNT_W-1:0] timeout_q, count;
  logic [15:0] rd_next, cnt_word;

  assign idx = addr[IDX_W+1:2];

  kwdt_ctrl #(.CNT_W(CNT_W), .DEF_TIMEOUT(DEF_TIMEOUT)) ctrl_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .idx(idx), .wdata(wdata),
    .feed_hit(feed_hit), .clr_hit(clr_hit), .ack_hit(ack_hit),
    .enabled(enabled), .dbg_run(dbg_run), .mask_q(mask_q),
    .force_q(force_q), .timeout_q(timeout_q));

  assign running = enabled && (!dbg_mode || dbg_run);

  kwdt_counter #(.CNT_W(CNT_W), .DEF_TIMEOUT(DEF_TIMEOUT)) cnt_i (
    .clk(clk), .rst(rst), .tick(tick), .running(running), .feed(feed_hit),
    .clr(clr_hit), .timeout(timeout_q), .count(count),
    .expired_q(expired_q), .warn(warn), .reset_req(reset_req));

  kwdt_irq irq_i (
    .clk(clk), .rst(rst), .warn(warn), .force_q(force_q), .ack(ack_hit),
    .mask_q(mask_q), .evt_q(evt_q), .irq(irq));

  always_comb begin
    cnt_word = '0;
    cnt_word[CNT_W-1:0] = count;
    cnt_word[15] = tick && running;
    rd_next = '0;
    case (idx)
      IX_TMO:   rd_next[CNT_W-1:0] = timeout_q;
      IX_DIS2:  rd_next = enabled ? 16'h0000 : C_OFF;
      IX_STAT:  rd_next = expired_q ? C_EXPIRED : 16'h0000;
      IX_CNT:   rd_next = cnt_word;
      IX_DBG:   rd_next[1:0] = {dbg_mode, dbg_run};
      IX_EVT:   rd_next[0] = evt_q;
      IX_MASK:  rd_next[0] = mask_q;
      IX_FORCE: rd_next[0] = force_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else rdata <= rd_next;
  end

  // R5
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (reset_req && !tick) |=> !reset_req);
endmodule

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
  localparam int DEF_T = 6000;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, dbg_mode = 1'b0, wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic irq, reset_req;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  kwdt_top dut_i (.clk(clk), .rst(rst), .tick(tick), .dbg_mode(dbg_mode),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
    .reset_req(reset_req));

  always #2.5ns clk = ~clk;

  function automatic logic [15:0] exp_count(input int t, input int k);
    return 16'(t - k);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [15:0] v;
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(6'h0C, v); check("R1 disabled", v, 16'hDABE);
    rd(6'h10, v); check("R1 status", v, 16'h0000);
    rd(6'h14, v); check("R1 count", v, 16'(DEF_T));
    check("R1 irq/req", {14'b0, irq, reset_req}, 16'h0);
    // R4 ticks ignored while disabled
    ticks(3); rd(6'h14, v); check("R4 disabled hold", v, 16'(DEF_T));
    // R7 wrong restart, then right one
    wr(6'h1C, 16'hACEE); rd(6'h0C, v); check("R7 wrong key", v, 16'hDABE);
    wr(6'h1C, 16'hACED); rd(6'h0C, v); check("R7 enabled", v, 16'h0000);
    // R3 timeout masking
    wr(6'h04, 16'hFFFF); rd(6'h04, v); check("R3 mask", v, 16'h7FFF);
    wr(6'h04, 16'd10); rd(6'h04, v); check("R3 readback", v, 16'd10);
    // R2 feed
    wr(6'h00, 16'hFEED); rd(6'h14, v); check("R2 feed reload", v, 16'd10);
    ticks(4); rd(6'h14, v); check("R4 decrement", v, 16'd6);
    wr(6'h00, 16'hFEEE); rd(6'h14, v); check("R2 wrong key ignored", v, 16'd6);
    // R9 stability flag
    @(negedge clk); addr = 6'h14; tick = 1'b1;
    @(negedge clk); tick = 1'b0; check("R9 transition flag", rdata, 16'h8006);
    rd(6'h14, v); check("R9 stable", v, 16'd5);
    // R12 debug hold
    dbg_mode = 1'b1;
    rd(6'h18, v); check("R12 debug read", v, 16'h0002);
    ticks(2); rd(6'h14, v); check("R12 held", v, 16'd5);
    wr(6'h18, 16'h0001); rd(6'h18, v); check("R12 allow read", v, 16'h0003);
    ticks(1); rd(6'h14, v); check("R12 allowed run", v, 16'd4);
    dbg_mode = 1'b0;
    // R6 aborted sequence then proper sequence
    wr(6'h08, 16'h2BAD); wr(6'h04, 16'd10); wr(6'h0C, 16'hCAFE);
    rd(6'h0C, v); check("R6 aborted", v, 16'h0000);
    wr(6'h0C, 16'hCAFE); rd(6'h0C, v); check("R6 no arm", v, 16'h0000);
    wr(6'h08, 16'h2BAD); wr(6'h0C, 16'hCAFE);
    rd(6'h0C, v); check("R6 disabled", v, 16'hDABE);
    wr(6'h1C, 16'hACED);
    // R5 R10 expiry path with timeout 3
    wr(6'h04, 16'd3); wr(6'h00, 16'hFEED);
    ticks(3);
    rd(6'h20, v); check("R10 event set", v, 16'h0001);
    check("R10 masked irq", {15'b0, irq}, 16'h0);
    wr(6'h24, 16'h0001); @(negedge clk);
    check("R10 irq", {15'b0, irq}, 16'h1);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check("R5 reset_req pulse", {15'b0, reset_req}, 16'h1);
    @(negedge clk); check("R5 single pulse", {15'b0, reset_req}, 16'h0);
    rd(6'h14, v); check("R5 reload", v, 16'd3);
    rd(6'h10, v); check("R8 expired", v, 16'hCFE8);
    wr(6'h10, 16'h1234); rd(6'h10, v); check("R8 wrong clear", v, 16'hCFE8);
    wr(6'h10, 16'hE8B4); rd(6'h10, v); check("R8 cleared", v, 16'h0000);
    wr(6'h20, 16'h0001); rd(6'h20, v); check("R10 ack", v, 16'h0000);
    @(negedge clk); check("R10 irq drop", {15'b0, irq}, 16'h0);
    // R11 force
    wr(6'h28, 16'h0001); wr(6'h20, 16'h0001);
    rd(6'h20, v); check("R11 forced", v, 16'h0001);
    wr(6'h28, 16'h0000); wr(6'h20, 16'h0001);
    rd(6'h20, v); check("R11 released", v, 16'h0000);
    // R2 R4 random feeds and ticks
    for (int it = 0; it < 20; it++) begin
      int t, k;
      t = 5 + int'($urandom_range(40));
      k = int'($urandom_range(t - 2));
      wr(6'h04, 16'(t)); wr(6'h00, 16'hFEED);
      ticks(k);
      if ($urandom_range(1) == 1) wr(6'h00, 16'($urandom_range(16'hFEEC)));
      rd(6'h14, v); check("R4 random count", v, exp_count(t, k));
    end
    finish_up();
  end
endmodule